// File: doc/BRIEF.md
# Error Pin Controller with Key Release

This block owns the active-low error output of a safety error collector. Each clock it looks at a vector of error events, masks them with per-bit enables, and records every enabled event in a status register that software clears by writing ones. The first enabled event pulls the pin low. Any later enabled event keeps it low and restarts a minimum low-time counter from a programmable preload value.

Software never releases the pin directly. It writes a release key to a key port while the pin is low, which arms a release request. The pin returns high at the first clock edge where the request is armed and the low-time counter has reached zero. A new enabled event while the request is armed cancels it, so software must write the key again. Clearing status bits never touches the pin. A single-cycle error pulse, such as the one a forced-error self-test injects, has the same effect as a real fault.

Top module: `errpin_ctrl`

## Requirements
- R1: While and after power-on reset (rst_n low), err_n_o is 1, rel_pend_o is 0 and sts_o is all zeros.
- R2: An event bit i with evt_en_i[i]=1, sampled at a rising edge, drives err_n_o to 0 after that edge. An event on a bit whose enable is 0 leaves the pin level and its status bit unchanged.
- R3: A single-cycle enabled event pulse holds err_n_o at 0 indefinitely until a release key is written.
- R4: A key write (key_we_i=1) with key_wdata_i equal to RELEASE_KEY (default 4'h5) while err_n_o is 0 sets rel_pend_o after that edge. Any other key value, such as 4'h0 or 4'h3, sets nothing. Any key write while err_n_o is 1 is ignored.
- R5: The low-time counter loads low_time_i on the edge of an enabled event and then decrements once per cycle. With a request armed, err_n_o returns to 1, and rel_pend_o to 0, on the edge after the counter reaches zero. If the key is written in the cycle right after the event, the pin stays low for exactly low_time_i+1 cycles.
- R6: An enabled event while the pin is low reloads the counter, so the minimum low time counts from the most recent event.
- R7: An enabled event while a request is armed clears rel_pend_o at that edge and keeps err_n_o at 0. Only a fresh key write releases the pin.
- R8: Each enabled event sets its bit in sts_o. A write with sts_w1c_i=1 clears the bits where sts_wdata_i is 1; if an event and a clear hit the same bit in the same cycle, the event wins. Status bits never clear without a write, and clearing them never changes err_n_o.
- R9: If a release key write and an enabled event arrive in the same cycle, the event wins: rel_pend_o stays 0 and the pin stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| evt_i | input | N_EVT | Error event inputs, one per source |
| evt_en_i | input | N_EVT | Per-event enable for pin and status |
| key_we_i | input | 1 | Key register write strobe |
| key_wdata_i | input | KEY_W | Key register write data |
| sts_w1c_i | input | 1 | Status write strobe (write one to clear) |
| sts_wdata_i | input | N_EVT | Status clear mask |
| low_time_i | input | CNT_W | Minimum low-time preload in cycles |
| sts_o | output | N_EVT | Latched status of enabled events |
| rel_pend_o | output | 1 | Release request armed |
| err_n_o | output | 1 | Active-low error pin |

## Verification
The hardest situation to reach is the race between an armed release and a fresh fault. An event must land after the key write but before the counter expires, and a separate case has the key and the event arrive in the very same cycle. The bench reaches both by writing the key on the cycle right after a first pulse, then injecting a second pulse a known number of cycles later. It then counts low cycles edge by edge from the last event, so a counter that failed to reload, or a request that survived the new event, shows up as an early rise of the pin.

// File: rtl/errpin_pkg.sv
`timescale 1ns/1ps
package errpin_pkg;

   // Pin controller states; only PIN_IDLE drives the pin high.
   typedef enum logic [1:0] {
      PIN_IDLE  = 2'd0,
      PIN_HELD  = 2'd1,
      PIN_ARMED = 2'd2
   } pin_state_e;

   // Reduction helper used by the event capture stage.
   function automatic logic any_set(input logic [63:0] vec);
      return |vec;
   endfunction

endpackage

// File: rtl/errpin_evt_cap.sv
`timescale 1ns/1ps
module errpin_evt_cap #(
   parameter int N_EVT   = 8,
   parameter int EVT_REG = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_i,
   input  logic [N_EVT-1:0] evt_en_i,
   input  logic             sts_w1c_i,
   input  logic [N_EVT-1:0] sts_wdata_i,
   output logic             hit_o,
   output logic [N_EVT-1:0] sts_o
);
   import errpin_pkg::*;

   localparam int PADW = 64 - N_EVT;

   logic [N_EVT-1:0] masked;
   logic [N_EVT-1:0] stage;
   logic [N_EVT-1:0] sts_q;

   assign masked = evt_i & evt_en_i;

   generate
      if (EVT_REG != 0) begin : g_evt_reg
         logic [N_EVT-1:0] masked_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) masked_q <= '0;
            else        masked_q <= masked;
         end
         assign stage = masked_q;
      end else begin : g_evt_comb
         assign stage = masked;
      end
   endgenerate

   generate
      if (PADW > 0) begin : g_pad
         assign hit_o = any_set({{PADW{1'b0}}, stage});
      end else begin : g_nopad
         assign hit_o = any_set(stage[63:0]);
      end
   endgenerate

   // Status bits: set has priority over write-one-to-clear.
   for (genvar i = 0; i < N_EVT; i++) begin : g_sts
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sts_q[i] <= 1'b0;
         else if (stage[i])
            sts_q[i] <= 1'b1;
         else if (sts_w1c_i && sts_wdata_i[i])
            sts_q[i] <= 1'b0;
      end
   end

   assign sts_o = sts_q;

endmodule

// File: rtl/errpin_lowtime.sv
`timescale 1ns/1ps
module errpin_lowtime #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] preload_i,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= preload_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/errpin_fsm.sv
`timescale 1ns/1ps
module errpin_fsm #(
   parameter int              KEY_W       = 4,
   parameter logic [KEY_W-1:0] RELEASE_KEY = 4'h5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_i,
   input  logic             cnt_zero_i,
   input  logic             key_we_i,
   input  logic [KEY_W-1:0] key_wdata_i,
   output logic             err_n_o,
   output logic             pend_o
);
   import errpin_pkg::*;

   pin_state_e state_q, state_d;
   logic       err_n_q;
   logic       key_ok;

   assign key_ok = key_we_i && (key_wdata_i == RELEASE_KEY);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PIN_IDLE:  if (hit_i) state_d = PIN_HELD;
         PIN_HELD:  if (!hit_i && key_ok) state_d = PIN_ARMED;
         PIN_ARMED: begin
            if (hit_i)           state_d = PIN_HELD;
            else if (cnt_zero_i) state_d = PIN_IDLE;
         end
         default:   state_d = PIN_HELD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PIN_IDLE;
         err_n_q <= 1'b1;
      end else begin
         state_q <= state_d;
         err_n_q <= (state_d == PIN_IDLE);
      end
   end

   assign err_n_o = err_n_q;
   assign pend_o  = (state_q == PIN_ARMED);

endmodule

// File: rtl/errpin_ctrl.sv
`timescale 1ns/1ps
module errpin_ctrl #(
   parameter int               N_EVT       = 8,
   parameter int               CNT_W       = 16,
   parameter int               KEY_W       = 4,
   parameter logic [KEY_W-1:0] RELEASE_KEY = 4'h5,
   parameter int               EVT_REG     = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_i,
   input  logic [N_EVT-1:0] evt_en_i,
   input  logic             key_we_i,
   input  logic [KEY_W-1:0] key_wdata_i,
   input  logic             sts_w1c_i,
   input  logic [N_EVT-1:0] sts_wdata_i,
   input  logic [CNT_W-1:0] low_time_i,
   output logic [N_EVT-1:0] sts_o,
   output logic             rel_pend_o,
   output logic             err_n_o
);

   generate
      if (N_EVT < 1 || N_EVT > 64) begin : g_bad_nevt
         $error("errpin_ctrl: N_EVT must be 1..64");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cntw
         $error("errpin_ctrl: CNT_W must be 1..32");
      end
      if (KEY_W < 2) begin : g_bad_keyw
         $error("errpin_ctrl: KEY_W must be at least 2");
      end
      if (RELEASE_KEY == '0) begin : g_bad_key
         $error("errpin_ctrl: RELEASE_KEY must be non-zero");
      end
   endgenerate

   logic hit;
   logic cnt_zero;

   errpin_evt_cap #(
      .N_EVT   (N_EVT),
      .EVT_REG (EVT_REG)
   ) cap_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt_i),
      .evt_en_i    (evt_en_i),
      .sts_w1c_i   (sts_w1c_i),
      .sts_wdata_i (sts_wdata_i),
      .hit_o       (hit),
      .sts_o       (sts_o)
   );

   errpin_lowtime #(
      .CNT_W (CNT_W)
   ) lt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (hit),
      .preload_i (low_time_i),
      .zero_o    (cnt_zero)
   );

   errpin_fsm #(
      .KEY_W       (KEY_W),
      .RELEASE_KEY (RELEASE_KEY)
   ) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit_i       (hit),
      .cnt_zero_i  (cnt_zero),
      .key_we_i    (key_we_i),
      .key_wdata_i (key_wdata_i),
      .err_n_o     (err_n_o),
      .pend_o      (rel_pend_o)
   );

endmodule

// File: rtl/errpin_chk.sv
`timescale 1ns/1ps
module errpin_chk #(
   parameter int               N_EVT       = 8,
   parameter int               CNT_W       = 16,
   parameter int               KEY_W       = 4,
   parameter logic [KEY_W-1:0] RELEASE_KEY = 4'h5,
   parameter int               EVT_REG     = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_EVT-1:0] evt_i,
   input logic [N_EVT-1:0] evt_en_i,
   input logic             key_we_i,
   input logic [KEY_W-1:0] key_wdata_i,
   input logic             sts_w1c_i,
   input logic [N_EVT-1:0] sts_wdata_i,
   input logic [CNT_W-1:0] low_time_i,
   input logic [N_EVT-1:0] sts_o,
   input logic             rel_pend_o,
   input logic             err_n_o
);
   logic hit_raw;
   logic hit_c;

   assign hit_raw = |(evt_i & evt_en_i);

   generate
      if (EVT_REG != 0) begin : g_dly
         logic hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= hit_raw;
         end
         assign hit_c = hit_q;
      end else begin : g_nodly
         assign hit_c = hit_raw;
      end
   endgenerate

   // R2
   evt_pulls_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_c |=> !err_n_o);

   // R7
   evt_cancels_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_c |=> !rel_pend_o);

   // R4
   bad_key_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_we_i && key_wdata_i != RELEASE_KEY && !rel_pend_o) |=> !rel_pend_o);

   // R4
   high_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_n_o |-> !rel_pend_o);

   // R5
   rise_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_n_o) |-> $past(rel_pend_o));

   // R8
   sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_w1c_i |=> ((sts_o & $past(sts_o)) == $past(sts_o)));

endmodule

bind errpin_ctrl errpin_chk #(
   .N_EVT       (N_EVT),
   .CNT_W       (CNT_W),
   .KEY_W       (KEY_W),
   .RELEASE_KEY (RELEASE_KEY),
   .EVT_REG     (EVT_REG)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_i       (evt_i),
   .evt_en_i    (evt_en_i),
   .key_we_i    (key_we_i),
   .key_wdata_i (key_wdata_i),
   .sts_w1c_i   (sts_w1c_i),
   .sts_wdata_i (sts_wdata_i),
   .low_time_i  (low_time_i),
   .sts_o       (sts_o),
   .rel_pend_o  (rel_pend_o),
   .err_n_o     (err_n_o)
);

// File: tb/errpin_ctrl_tb_top.sv
`timescale 1ns/1ps
module errpin_ctrl_tb_top;
   localparam int N = 8;
   localparam int W = 16;
   localparam int LT = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] evt = '0;
   logic [N-1:0] en = '1;
   logic         key_we = 1'b0;
   logic [3:0]   key_wdata = '0;
   logic         w1c = 1'b0;
   logic [N-1:0] wdata = '0;
   logic [W-1:0] low_time = W'(LT);
   logic [N-1:0] sts;
   logic         pend;
   logic         err_n;

   int checks = 0;
   int errs = 0;

   always #4 clk = ~clk;

   errpin_ctrl dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .evt_en_i    (en),
      .key_we_i    (key_we),
      .key_wdata_i (key_wdata),
      .sts_w1c_i   (w1c),
      .sts_wdata_i (wdata),
      .low_time_i  (low_time),
      .sts_o       (sts),
      .rel_pend_o  (pend),
      .err_n_o     (err_n)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic pulse_evt(input logic [N-1:0] v);
      evt = v;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic write_key(input logic [3:0] v);
      key_we = 1'b1;
      key_wdata = v;
      @(negedge clk);
      key_we = 1'b0;
      key_wdata = '0;
   endtask

   // Called one negedge after the key write that followed the last event.
   task automatic measure_release(input string req);
      for (int k = 0; k < LT - 1; k++) begin
         chk(req, "pin low during low time", 32'(err_n), 32'd0);
         @(negedge clk);
      end
      chk(req, "pin low at last low cycle", 32'(err_n), 32'd0);
      @(negedge clk);
      chk(req, "pin high after low time", 32'(err_n), 32'd1);
      chk(req, "request cleared on release", 32'(pend), 32'd0);
   endtask

   task automatic restore_high();
      write_key(4'h5);
      for (int k = 0; k < 40 && !err_n; k++) @(negedge clk);
      chk("R5", "pin restored high", 32'(err_n), 32'd1);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1", "pin in reset", 32'(err_n), 32'd1);
      chk("R1", "request in reset", 32'(pend), 32'd0);
      chk("R1", "status in reset", 32'(sts), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "pin after reset", 32'(err_n), 32'd1);
   endtask

   task automatic t_basic_release();
      pulse_evt(8'h01);
      chk("R2", "pin low after event", 32'(err_n), 32'd0);
      write_key(4'h5);
      chk("R4", "request armed by key", 32'(pend), 32'd1);
      measure_release("R5");
      write_key(4'h0);
      chk("R4", "zero key while high ignored", 32'(err_n), 32'd1);
   endtask

   task automatic t_retrigger();
      pulse_evt(8'h02);
      repeat (2) @(negedge clk);
      pulse_evt(8'h02);
      write_key(4'h5);
      measure_release("R6");
   endtask

   task automatic t_cancel();
      pulse_evt(8'h01);
      write_key(4'h5);
      chk("R7", "request armed", 32'(pend), 32'd1);
      pulse_evt(8'h04);
      chk("R7", "request cancelled by event", 32'(pend), 32'd0);
      chk("R7", "pin low after cancel", 32'(err_n), 32'd0);
      repeat (LT + 4) @(negedge clk);
      chk("R7", "pin still low without new key", 32'(err_n), 32'd0);
      write_key(4'h5);
      chk("R7", "fresh key arms", 32'(pend), 32'd1);
      @(negedge clk);
      chk("R7", "fresh key releases", 32'(err_n), 32'd1);
   endtask

   task automatic t_ignore();
      write_key(4'h5);
      chk("R4", "key while high no request", 32'(pend), 32'd0);
      chk("R4", "key while high pin", 32'(err_n), 32'd1);
      pulse_evt(8'h10);
      write_key(4'h3);
      chk("R4", "wrong key no request", 32'(pend), 32'd0);
      write_key(4'h0);
      chk("R4", "zero key no request", 32'(pend), 32'd0);
      repeat (LT + 3) @(negedge clk);
      chk("R4", "pin low after wrong keys", 32'(err_n), 32'd0);
      restore_high();
   endtask

   task automatic t_selftest();
      pulse_evt(8'h80);
      chk("R3", "single pulse pulls low", 32'(err_n), 32'd0);
      repeat (40) @(negedge clk);
      chk("R3", "pin held low without key", 32'(err_n), 32'd0);
      restore_high();
   endtask

   task automatic t_collide();
      pulse_evt(8'h01);
      repeat (LT + 2) @(negedge clk);
      evt = 8'h08;
      key_we = 1'b1;
      key_wdata = 4'h5;
      @(negedge clk);
      evt = '0;
      key_we = 1'b0;
      chk("R9", "no request on collision", 32'(pend), 32'd0);
      chk("R9", "pin low on collision", 32'(err_n), 32'd0);
      @(negedge clk);
      chk("R9", "pin still low", 32'(err_n), 32'd0);
      restore_high();
   endtask

   task automatic t_status();
      w1c = 1'b1; wdata = '1;
      @(negedge clk);
      w1c = 1'b0; wdata = '0;
      chk("R8", "status cleared", 32'(sts), 32'd0);
      en = 8'hDF;
      pulse_evt(8'h20);
      chk("R2", "disabled event status", 32'(sts), 32'd0);
      chk("R2", "disabled event pin", 32'(err_n), 32'd1);
      pulse_evt(8'h04);
      chk("R8", "enabled event sets bit", 32'(sts), 32'h04);
      w1c = 1'b1; wdata = 8'h04;
      @(negedge clk);
      w1c = 1'b0; wdata = '0;
      chk("R8", "w1c clears bit", 32'(sts), 32'h00);
      chk("R8", "clear leaves pin low", 32'(err_n), 32'd0);
      evt = 8'h08; w1c = 1'b1; wdata = 8'h08;
      @(negedge clk);
      evt = '0; w1c = 1'b0; wdata = '0;
      chk("R8", "set wins over clear", 32'(sts), 32'h08);
      en = '1;
      restore_high();
   endtask

   initial begin
      t_reset();
      t_basic_release();
      t_retrigger();
      t_cancel();
      t_ignore();
      t_selftest();
      t_collide();
      t_status();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule